// File: doc/BRIEF.md
# Decoder-Based Minterm Function Generator

This block evaluates a fixed three-input Boolean function by first fully decoding the three select inputs into eight active-low minterm lines and then combining the chosen lines with a single NAND. The function implemented is F1 = B·A' + A·B·C. Its true minterms are 2, 6 and 7, counted with C as the most significant select bit. So F1 is the NAND of decoder lines 2, 6 and 7.

The eight-line decoder is built from two four-line sections. Both sections share the two low select bits, B and A. Each section also has a one-bit data line, and the two data lines are tied together to carry C. The lower section accepts that line in true polarity inverted and the upper section accepts it in true polarity, so C steers the selection to one half or the other. The two section strobes are tied together to form one active-low enable. The eight decoder lines are exposed as outputs, so the block can also be used as a plain 3-to-8 decoder.

The block is purely combinational: it has no clock, no reset and no state.

Top module: `minterm_fgen`

## Requirements
- R1: With `en_n` = 0, exactly one bit of `dec_n` is 0, and its index equals the select code {C,B,A}, where `sel_c` is bit 2, `sel_b` is bit 1 and `sel_a` is bit 0.
- R2: With `en_n` = 1, all eight bits of `dec_n` are 1 for every select code.
- R3: With `en_n` = 0, `f1` equals (B AND NOT A) OR (A AND B AND C). It is therefore 1 exactly for the codes 2, 6 and 7.
- R4: With `en_n` = 1, `f1` is 0 for every select code.
- R5: Lines 0 to 3 of `dec_n` can go low only while `sel_c` = 0. Lines 4 to 7 can go low only while `sel_c` = 1.
- R6: `f1` is always the NAND of `dec_n[2]`, `dec_n[6]` and `dec_n[7]`.
- R7: Outputs are a pure function of the present inputs. After any input change they settle before the next clock edge of the surrounding logic, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_c | input | 1 | Select bit C (most significant); drives the section data lines |
| sel_b | input | 1 | Select bit B |
| sel_a | input | 1 | Select bit A (least significant) |
| en_n | input | 1 | Active-low enable shared by both sections |
| dec_n | output | 8 | Active-low decoder lines, index = {C,B,A} |
| f1 | output | 1 | Function output, NAND of lines 2, 6 and 7 |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and `dec_n` or `f1`. The bench changes the inputs just after a rising edge and compares both outputs with its behavioural model at the following falling edge. By then the combinational paths have settled, and no new stimulus has yet been applied. The sweep covers all eight select codes with the enable low and with it high, followed by a scrambled sequence. In that sequence both the enable and the select bits change together in the same cycle.

// File: rtl/minterm_fgen_pkg.sv
// Package: shared sizing for the minterm function generator.
// Assumes: two equal decoder sections, each decoding SECT_SEL_W select bits.
package minterm_fgen_pkg;
    localparam int SECT_SEL_W = 2;
    localparam int SECT_OUTS  = 1 << SECT_SEL_W;
    localparam int N_SECTS    = 2;
    localparam int DEC_OUTS   = SECT_OUTS * N_SECTS;
    // Minterms 2, 6 and 7 of F1 = B.A' + A.B.C
    localparam logic [DEC_OUTS-1:0] F1_MINTERMS = 8'b1100_0100;
endpackage

// File: rtl/mfg_dec_section.sv
// Module: one 2-to-4 decoder section with active-low outputs.
// It is active when its strobe is low and its data line matches its polarity.
// The polarity parameter picks an active-high or active-low data input.
// Assumes: a purely combinational use; no state.
module mfg_dec_section #(
    parameter int SEL_W            = 2,
    parameter bit DATA_ACTIVE_HIGH = 1'b1,
    localparam int OUTS            = 1 << SEL_W
) (
    input  logic             data_i,
    input  logic             strobe_n,
    input  logic [SEL_W-1:0] sel,
    output logic [OUTS-1:0]  out_n
);
    logic data_hit;

    // Pick the data-line polarity for this section.
    generate
        if (DATA_ACTIVE_HIGH) begin : g_hi
            assign data_hit = data_i;
        end else begin : g_lo
            assign data_hit = ~data_i;
        end
    endgenerate

    // Drive the selected line low; all lines stay high when inactive.
    always_comb begin
        out_n = '1;
        if (!strobe_n && data_hit) begin
            out_n[sel] = 1'b0;
        end
    end
endmodule

// File: rtl/mfg_decoder.sv
// Module: 3-to-8 active-low decoder formed from two 2-to-4 sections.
// The data lines are tied together as the upper select bit, and the strobes
// are tied together as the enable.
// Assumes: section 0 is the lower half and takes an inverted data line.
module mfg_decoder
    import minterm_fgen_pkg::*;
(
    input  logic                  hi_sel,
    input  logic [SECT_SEL_W-1:0] lo_sel,
    input  logic                  en_n,
    output logic [DEC_OUTS-1:0]   dec_n
);
    // Instantiate one section per half, with alternating data polarity.
    generate
        for (genvar s = 0; s < N_SECTS; s++) begin : g_sect
            mfg_dec_section #(
                .SEL_W            (SECT_SEL_W),
                .DATA_ACTIVE_HIGH (s == 1)
            ) u_sect (
                .data_i   (hi_sel),
                .strobe_n (en_n),
                .sel      (lo_sel),
                .out_n    (dec_n[s*SECT_OUTS +: SECT_OUTS])
            );
        end
    endgenerate
endmodule

// File: rtl/mfg_minterm_nand.sv
// Module: NAND of the active-low lines chosen by a mask.
// An unmasked line is forced high, so it does not affect the NAND.
// Assumes: MASK has at least one bit set.
module mfg_minterm_nand #(
    parameter int              N    = 8,
    parameter logic [N-1:0]    MASK = '1
) (
    input  logic [N-1:0] lines_n,
    output logic         y
);
    logic [N-1:0] gated;

    // Force every unmasked line high.
    generate
        for (genvar i = 0; i < N; i++) begin : g_gate
            if (MASK[i]) begin : g_use
                assign gated[i] = lines_n[i];
            end else begin : g_skip
                assign gated[i] = 1'b1;
            end
        end
    endgenerate

    // Multi-input NAND of the gated lines.
    always_comb y = ~(&gated);
endmodule

// File: rtl/minterm_fgen.sv
// Module: top of the minterm function generator (decoder plus NAND).
// Assumes: combinational only; the enable is active low.
module minterm_fgen
    import minterm_fgen_pkg::*;
#(
    parameter logic [DEC_OUTS-1:0] MINTERM_MASK = F1_MINTERMS
) (
    input  logic                sel_c,
    input  logic                sel_b,
    input  logic                sel_a,
    input  logic                en_n,
    output logic [DEC_OUTS-1:0] dec_n,
    output logic                f1
);
    // Full decode of the select code into minterm lines.
    mfg_decoder u_dec (
        .hi_sel (sel_c),
        .lo_sel ({sel_b, sel_a}),
        .en_n   (en_n),
        .dec_n  (dec_n)
    );

    // Combine the chosen minterm lines into F1.
    mfg_minterm_nand #(
        .N    (DEC_OUTS),
        .MASK (MINTERM_MASK)
    ) u_nand (
        .lines_n (dec_n),
        .y       (f1)
    );
endmodule

// File: rtl/minterm_fgen_chk.sv
// Checker: immediate assertions on the port behaviour of minterm_fgen.
// Assumes: the inputs are known values; each check waits until they are.
module minterm_fgen_chk (
    input logic       sel_c,
    input logic       sel_b,
    input logic       sel_a,
    input logic       en_n,
    input logic [7:0] dec_n,
    input logic       f1
);
    logic known;

    // Evaluate each check only once the inputs are known.
    always_comb begin
        known = !$isunknown({sel_c, sel_b, sel_a, en_n});
        if (known) begin
            p_one_low_r1: assert (en_n || ($countones(~dec_n) == 1 &&
                                  dec_n[{sel_c, sel_b, sel_a}] == 1'b0))
                else $error("R1 decode");
            p_idle_high_r2: assert (!en_n || dec_n == 8'hFF)
                else $error("R2 idle");
            p_f1_off_r4: assert (!en_n || f1 == 1'b0)
                else $error("R4 f1");
            p_half_steer_r5: assert (sel_c ? (dec_n[3:0] == 4'hF) : (dec_n[7:4] == 4'hF))
                else $error("R5 steer");
            p_nand_rel_r6: assert (f1 == !(dec_n[2] && dec_n[6] && dec_n[7]))
                else $error("R6 nand");
            p_onehot_low_r1: assert ($onehot0(~dec_n))
                else $error("R1 onehot");
        end
    end
endmodule

bind minterm_fgen minterm_fgen_chk u_chk (
    .sel_c (sel_c),
    .sel_b (sel_b),
    .sel_a (sel_a),
    .en_n  (en_n),
    .dec_n (dec_n),
    .f1    (f1)
);

// File: tb/minterm_fgen_test.sv
module minterm_fgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_c = 1'b0, sel_b = 1'b0, sel_a = 1'b0;
    logic       en_n = 1'b1;
    logic [7:0] dec_n;
    logic       f1;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    minterm_fgen uut (
        .sel_c (sel_c),
        .sel_b (sel_b),
        .sel_a (sel_a),
        .en_n  (en_n),
        .dec_n (dec_n),
        .f1    (f1)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (en_n=%0b code=%0d)",
                     req, act, exp, en_n, {sel_c, sel_b, sel_a});
        end
    endtask

    // Behavioural model: compare every output, sampled mid-cycle.
    task automatic apply(input bit en, input int code);
        logic [7:0] exp_dec;
        bit         b, a, c, exp_f;
        @(posedge clk);
        #1;
        en_n = en; sel_c = code[2]; sel_b = code[1]; sel_a = code[0];
        @(negedge clk);
        c = code[2]; b = code[1]; a = code[0];
        exp_dec = en ? 8'hFF : ~(8'h01 << code);
        exp_f   = !en && ((b && !a) || (a && b && c));
        if (en) begin
            chk("R2", dec_n, 8'hFF);
            chk("R4", {7'b0, f1}, 8'h00);
        end else begin
            chk("R1", dec_n, exp_dec);
            chk("R3", {7'b0, f1}, {7'b0, exp_f});
            chk("R5", c ? {4'h0, dec_n[3:0]} : {4'h0, dec_n[7:4]}, 8'h0F);
        end
        chk("R6", {7'b0, f1}, {7'b0, !(dec_n[2] && dec_n[6] && dec_n[7])});
        chk("R7", {dec_n[7:1], f1}, {exp_dec[7:1], exp_f});
    endtask

    initial begin
        // Watchdog.
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", dec_n, 8'hFF);            // reset state: disabled
        chk("R4", {7'b0, f1}, 8'h00);
        for (int e = 0; e < 2; e++)
            for (int k = 0; k < 8; k++)
                apply(e[0], k);
        // Scrambled sequence: enable and select bits move together.
        for (int k = 0; k < 24; k++)
            apply(((k * 5) % 3) == 1, (k * 3 + 1) % 8);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule